// File: doc/BRIEF.md
# H-Bridge PWM and Direction Gate Controller

This block produces the four gate-enable signals of an external full H-bridge: two high-side switches and two low-side switches. A PWM input and a direction input, both already synchronous to the clock, choose the drive pattern. In either direction one high-side switch stays on. On the opposite leg the low-side switch follows PWM and its high-side partner follows inverted PWM. Every change of PWM or direction starts a non-overlap hold. During the hold any switch that is about to turn on stays off, while switches that are turning off drop at once. The hold length in clock cycles comes from an input port.

The bridge is driven only while the enable condition is true. That condition needs a watchdog-synchronised flag, no under- or overvoltage, a healthy charge pump and no overtemperature shutdown. Per-switch desaturation comparators and a supply-drop comparator pass through counting filters. When a filter expires the block latches a short-circuit fault and turns every gate off. The next PWM transition clears the latch. Three registered diagnostic flags report short circuit, supply problems and overtemperature warning.

The state machine has two states. DT_RUN: outputs track the pattern. DT_HOLD: newly-on switches are masked while a counter runs down. Transitions are RUN→HOLD on a PWM/DIR change with a nonzero hold, HOLD→HOLD (counter reloaded) on a further change, HOLD→RUN when the counter reaches its last cycle or on a change with a zero hold, and RUN→RUN otherwise.

Top module: `hbridge_ctrl`

## Requirements
- R1: While rst_n is low all gates and diagnostic flags are low. One clock edge after the enable condition (sync_ok high, uv_flt low, ov_flt low, cp_ok high, ot_shut low) becomes false, all four gates are low. One edge after it returns, the gates follow the pattern again.
- R2: With dir_in=0, in steady state gate_hs1=1, gate_ls1=0, gate_hs2=!pwm_in and gate_ls2=pwm_in. The bench packs gates as {ls2,ls1,hs2,hs1}.
- R3: With dir_in=1, in steady state gate_hs1=!pwm_in, gate_ls1=pwm_in, gate_hs2=1 and gate_ls2=0.
- R4: A change of pwm_in or dir_in seen at clock edge E drops the switches that turn off at E. Switches that turn on stay off and rise at edge E+dead_cycles.
- R5: With dead_cycles=0, a new pattern appears whole at the first edge that sees the change.
- R6: When desat[i] is high for FLT_CYC consecutive edges while gate i is on, the short-circuit latch sets at the last of those edges. At that same edge all gates go low and diag_sc goes high. Bit order of desat is hs1, hs2, ls1, ls2 from bit 0.
- R7: The filter count restarts whenever its condition drops. A desat input on a switch that is off has no effect.
- R8: supply_drop held high for FLT_CYC consecutive edges has the same effect as R6.
- R9: The latch stays set until the next pwm_in transition. At that edge diag_sc clears and the drive resumes under the R4 hold rules.
- R10: diag_supply is high one edge after cp_ok is low, ov_flt is high or uv_flt is high. diag_temp is high one edge after ot_warn is high. ot_warn does not affect the gates.
- R11: pwm_in held high for any length keeps the pattern steady (100% duty) in either direction.
- R12: The high-side and low-side gate of one leg are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Synchronous PWM command |
| dir_in | input | 1 | Synchronous direction command |
| sync_ok | input | 1 | Watchdog has accepted a valid trigger |
| uv_flt | input | 1 | Battery undervoltage |
| ov_flt | input | 1 | Battery overvoltage |
| cp_ok | input | 1 | Charge pump voltage is sufficient |
| ot_shut | input | 1 | Overtemperature shutdown |
| ot_warn | input | 1 | Overtemperature warning |
| desat | input | 4 | Per-switch desaturation comparators {ls2,ls1,hs2,hs1} |
| supply_drop | input | 1 | Bridge supply below its short-circuit threshold |
| dead_cycles | input | DT_W | Non-overlap hold in clock cycles |
| gate_hs1 | output | 1 | High-side 1 gate enable |
| gate_hs2 | output | 1 | High-side 2 gate enable |
| gate_ls1 | output | 1 | Low-side 1 gate enable |
| gate_ls2 | output | 1 | Low-side 2 gate enable |
| diag_sc | output | 1 | Short-circuit latch |
| diag_supply | output | 1 | Charge pump, overvoltage or undervoltage flag |
| diag_temp | output | 1 | Overtemperature warning flag |

## Verification
The bench builds the block with FLT_CYC=4 and DT_W=4, where the default filter counts microseconds of clock cycles. With this setting the filter expiry and the restart-before-expiry cases each fit in a few cycles. The bench can then check the edge just before a trip as well as the trip edge. The hold is driven through the dead_cycles port at 3 and at 0. This covers both the masked path and the bypass path of the state machine without rebuilding the block.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        DT_RUN  = 1'b0,
        DT_HOLD = 1'b1
    } dt_state_e;

    localparam int SW_HS1 = 0;
    localparam int SW_HS2 = 1;
    localparam int SW_LS1 = 2;
    localparam int SW_LS2 = 3;
    localparam int SW_N   = 4;

    function automatic logic [SW_N-1:0] bridge_pattern(input logic pwm, input logic dir);
        logic [SW_N-1:0] p;
        if (!dir) begin
            p[SW_HS1] = 1'b1;
            p[SW_LS1] = 1'b0;
            p[SW_HS2] = !pwm;
            p[SW_LS2] = pwm;
        end else begin
            p[SW_HS1] = !pwm;
            p[SW_LS1] = pwm;
            p[SW_HS2] = 1'b1;
            p[SW_LS2] = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/hb_fault_filter.sv
module hb_fault_filter #(
    parameter int CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = cond && (cnt == LAST);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
    import hb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm,
    input  logic            dir,
    input  logic [DT_W-1:0] dead_cycles,
    output logic [SW_N-1:0] gate_dt,
    output logic            pwm_edge
);
    dt_state_e       state, nxt_state;
    logic [DT_W-1:0] cnt, nxt_cnt;
    logic [SW_N-1:0] gate_q, nxt_gate;
    logic            pwm_q, dir_q;
    logic            change;
    logic [SW_N-1:0] tgt;

    assign tgt      = bridge_pattern(pwm, dir);
    assign pwm_edge = pwm ^ pwm_q;
    assign change   = pwm_edge | (dir ^ dir_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= DT_RUN;
            cnt    <= '0;
            gate_q <= '0;
            pwm_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            state  <= nxt_state;
            cnt    <= nxt_cnt;
            gate_q <= nxt_gate;
            pwm_q  <= pwm;
            dir_q  <= dir;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_gate  = tgt;
        unique case (state)
            DT_RUN: begin
                if (change && (dead_cycles != '0)) begin
                    nxt_state = DT_HOLD;
                    nxt_cnt   = dead_cycles;
                    nxt_gate  = tgt & gate_q;
                end
            end
            DT_HOLD: begin
                if (change) begin
                    if (dead_cycles == '0) begin
                        nxt_state = DT_RUN;
                    end else begin
                        nxt_cnt  = dead_cycles;
                        nxt_gate = tgt & gate_q;
                    end
                end else if (cnt <= DT_W'(1)) begin
                    nxt_state = DT_RUN;
                end else begin
                    nxt_cnt  = cnt - 1'b1;
                    nxt_gate = tgt & gate_q;
                end
            end
        endcase
    end

    assign gate_dt = gate_q;

    // R4
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DT_HOLD) |-> ((gate_q & ~$past(gate_q)) == '0));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DT_W    = 8,
    parameter int FLT_CYC = 2500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            dir_in,
    input  logic            sync_ok,
    input  logic            uv_flt,
    input  logic            ov_flt,
    input  logic            cp_ok,
    input  logic            ot_shut,
    input  logic            ot_warn,
    input  logic [3:0]      desat,
    input  logic            supply_drop,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_hs1,
    output logic            gate_hs2,
    output logic            gate_ls1,
    output logic            gate_ls2,
    output logic            diag_sc,
    output logic            diag_supply,
    output logic            diag_temp
);
    localparam int N_FLT = SW_N + 1;

    logic [SW_N-1:0]  dt_gate, gate_now;
    logic             pwm_edge;
    logic             on_now, en_q, sc_q, sc_next, trip;
    logic             sup_q, tmp_q;
    logic [N_FLT-1:0] flt_cond, flt_hit;

    hb_deadtime #(.DT_W(DT_W)) u_dt (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm         (pwm_in),
        .dir         (dir_in),
        .dead_cycles (dead_cycles),
        .gate_dt     (dt_gate),
        .pwm_edge    (pwm_edge)
    );

    assign gate_now = dt_gate & {SW_N{en_q}};

    genvar gi;
    generate
        for (gi = 0; gi < N_FLT; gi++) begin : g_flt
            if (gi < SW_N) begin : g_sw
                assign flt_cond[gi] = desat[gi] & gate_now[gi];
            end else begin : g_sup
                assign flt_cond[gi] = supply_drop;
            end
            hb_fault_filter #(.CYC(FLT_CYC)) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .cond  (flt_cond[gi]),
                .hit   (flt_hit[gi])
            );
        end
    endgenerate

    assign on_now  = sync_ok & ~uv_flt & ~ov_flt & cp_ok & ~ot_shut;
    assign trip    = |flt_hit;
    assign sc_next = trip | (sc_q & ~pwm_edge);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q  <= 1'b0;
            en_q  <= 1'b0;
            sup_q <= 1'b0;
            tmp_q <= 1'b0;
        end else begin
            sc_q  <= sc_next;
            en_q  <= on_now & ~sc_next;
            sup_q <= ~cp_ok | ov_flt | uv_flt;
            tmp_q <= ot_warn;
        end
    end

    always_comb begin
        gate_hs1    = gate_now[SW_HS1];
        gate_hs2    = gate_now[SW_HS2];
        gate_ls1    = gate_now[SW_LS1];
        gate_ls2    = gate_now[SW_LS2];
        diag_sc     = sc_q;
        diag_supply = sup_q;
        diag_temp   = tmp_q;
    end

    // R12
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs1 && gate_ls1) && !(gate_hs2 && gate_ls2));

    // R1
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_now |=> (gate_now == '0));

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (diag_sc && gate_now == '0));

    // R10
    supply_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flt || ov_flt || !cp_ok) |=> diag_supply);

endmodule

// File: tb/hbridge_ctrl_bench.sv
module hbridge_ctrl_bench;
    localparam int DT_W    = 4;
    localparam int FLT_CYC = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            pwm_in, dir_in, sync_ok, uv_flt, ov_flt, cp_ok, ot_shut, ot_warn;
    logic [3:0]      desat;
    logic            supply_drop;
    logic [DT_W-1:0] dead_cycles;
    logic            gate_hs1, gate_hs2, gate_ls1, gate_ls2;
    logic            diag_sc, diag_supply, diag_temp;

    always #2 clk = ~clk;

    hbridge_ctrl #(.DT_W(DT_W), .FLT_CYC(FLT_CYC)) u_hbridge_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_in(dir_in),
        .sync_ok(sync_ok), .uv_flt(uv_flt), .ov_flt(ov_flt), .cp_ok(cp_ok),
        .ot_shut(ot_shut), .ot_warn(ot_warn), .desat(desat),
        .supply_drop(supply_drop), .dead_cycles(dead_cycles),
        .gate_hs1(gate_hs1), .gate_hs2(gate_hs2), .gate_ls1(gate_ls1),
        .gate_ls2(gate_ls2), .diag_sc(diag_sc), .diag_supply(diag_supply),
        .diag_temp(diag_temp)
    );

    typedef struct {
        int         due;
        logic [3:0] g;
        logic [2:0] d;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items when due and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            logic [3:0] g_obs;
            logic [2:0] d_obs;
            it    = q.pop_front();
            g_obs = {gate_ls2, gate_ls1, gate_hs2, gate_hs1};
            d_obs = {diag_temp, diag_supply, diag_sc};
            n_chk++;
            if (it.due != cyc || g_obs !== it.g || d_obs !== it.d) begin
                n_bad++;
                $display("FAIL %s: cycle %0d gates=%b diag=%b expected gates=%b diag=%b",
                         it.tag, cyc, g_obs, d_obs, it.g, it.d);
            end
        end
    end

    task automatic expect_in(input int k, input logic [3:0] g, input logic [2:0] d, input string tag);
        exp_t it;
        it.due = cyc + k;
        it.g   = g;
        it.d   = d;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; pwm_in = 1'b0; dir_in = 1'b0; sync_ok = 1'b1;
        uv_flt = 1'b0; ov_flt = 1'b0; cp_ok = 1'b1; ot_shut = 1'b0; ot_warn = 1'b0;
        desat = 4'b0; supply_drop = 1'b0; dead_cycles = DT_W'(3);
        step(2);
        expect_in(1, 4'b0000, 3'b000, "R1 reset");
        step(1);
        rst_n = 1'b1;
        expect_in(1, 4'b0011, 3'b000, "R2 dir0 pwm0");
        step(2);

        // R4 dead time, dir 0, pwm rise
        pwm_in = 1'b1;
        expect_in(1, 4'b0001, 3'b000, "R4 rise hold first");
        expect_in(3, 4'b0001, 3'b000, "R4 rise hold last");
        expect_in(4, 4'b1001, 3'b000, "R2 R4 ls2 on");
        step(5);
        pwm_in = 1'b0;
        expect_in(1, 4'b0001, 3'b000, "R4 fall hold first");
        expect_in(3, 4'b0001, 3'b000, "R4 fall hold last");
        expect_in(4, 4'b0011, 3'b000, "R2 R4 hs2 on");
        step(5);
        pwm_in = 1'b1;
        step(5);
        dir_in = 1'b1;
        expect_in(1, 4'b0000, 3'b000, "R4 R12 dir change hold");
        expect_in(3, 4'b0000, 3'b000, "R4 R12 dir change hold end");
        expect_in(4, 4'b0110, 3'b000, "R3 dir1 pwm1");
        step(5);
        expect_in(20, 4'b0110, 3'b000, "R11 full duty");
        step(21);

        // R5 zero hold
        dead_cycles = '0;
        pwm_in = 1'b0;
        expect_in(1, 4'b0011, 3'b000, "R5 R3 no hold");
        step(2);
        dead_cycles = DT_W'(3);

        // R1 / R10 enable condition and diagnostics
        uv_flt = 1'b1;
        expect_in(1, 4'b0000, 3'b010, "R1 R10 undervoltage");
        step(2);
        uv_flt = 1'b0;
        expect_in(1, 4'b0011, 3'b000, "R1 resume after uv");
        step(2);
        ov_flt = 1'b1;
        expect_in(1, 4'b0000, 3'b010, "R1 R10 overvoltage");
        step(2);
        ov_flt = 1'b0;
        step(2);
        cp_ok = 1'b0;
        expect_in(1, 4'b0000, 3'b010, "R1 R10 charge pump");
        step(2);
        cp_ok = 1'b1;
        step(2);
        ot_shut = 1'b1;
        expect_in(1, 4'b0000, 3'b000, "R1 ot shutdown");
        step(2);
        ot_shut = 1'b0;
        step(2);
        sync_ok = 1'b0;
        expect_in(1, 4'b0000, 3'b000, "R1 no sync");
        step(2);
        sync_ok = 1'b1;
        expect_in(1, 4'b0011, 3'b000, "R1 resume after sync");
        step(2);
        ot_warn = 1'b1;
        expect_in(1, 4'b0011, 3'b100, "R10 ot warning");
        step(2);
        ot_warn = 1'b0;
        expect_in(1, 4'b0011, 3'b000, "R10 warning clear");
        step(2);

        // R6 desat trip on hs1 (on)
        desat = 4'b0001;
        expect_in(3, 4'b0011, 3'b000, "R6 before expiry");
        expect_in(4, 4'b0000, 3'b001, "R6 trip");
        step(4);
        desat = 4'b0000;
        expect_in(5, 4'b0000, 3'b001, "R9 latch held");
        step(6);
        pwm_in = 1'b1;
        expect_in(1, 4'b0010, 3'b000, "R9 clear on pwm edge");
        expect_in(4, 4'b0110, 3'b000, "R9 resume after hold");
        step(5);

        // R7 restart and off switch
        desat = 4'b0010;
        step(3);
        desat = 4'b0000;
        step(1);
        desat = 4'b0010;
        step(3);
        desat = 4'b0000;
        expect_in(1, 4'b0110, 3'b000, "R7 restart no trip");
        step(2);
        desat = 4'b1000;
        expect_in(10, 4'b0110, 3'b000, "R7 off switch ignored");
        step(10);
        desat = 4'b0000;
        step(1);

        // R8 supply drop
        supply_drop = 1'b1;
        expect_in(3, 4'b0110, 3'b000, "R8 before expiry");
        expect_in(4, 4'b0000, 3'b001, "R8 trip");
        step(4);
        supply_drop = 1'b0;
        pwm_in = 1'b0;
        expect_in(1, 4'b0010, 3'b000, "R9 clear after supply drop");
        expect_in(4, 4'b0011, 3'b000, "R9 resume dir1 pwm0");
        step(5);

        while (q.size() > 0) step(1);
        done = 1'b1;
        report();
    end

endmodule